// File: doc/BRIEF.md
# Three-Phase Bridge Gate Interlock

This block is the digital core that sits between a motor-control modulator and the gate drivers of a three-phase half-bridge. For each phase it receives a high-side command, which is active-low, and a low-side command, which is active-high. It also receives a global disable, an undervoltage flag and a guard-enable strap. It drives six registered gate-enable outputs, one high and one low per phase.

While the strap is set, the block does three things to prevent shoot-through:
- An asserted low-side command wins over the high-side command of the same phase.
- Every turn-on is held back by a dead time counted in clock cycles.
- Every turn-off passes on the next register update.

A request that falls before its dead time has elapsed restarts the count, so a short glitch never produces a pulse. While the strap is clear, the outputs follow the commands directly, and both switches of a phase may be on at once.

After reset the block runs a start-up charge interval. During it, all low-side switches are turned on and all high-side switches are held off, so the bootstrap supplies can fill. The disable input and the undervoltage flag both force all six outputs off and take priority over everything else, including the charge interval. All external inputs pass through two-flop synchronizers.

Top module: `bridge_gate_interlock`

## Requirements
- R1: The high-side command is active-low. A 0 on `hi_cmd_n_i[i]` requests high gate `i` on and a 1 requests it off. A high-side turn-off appears at `hi_gate_o[i]` on the third rising edge after the input changes.
- R2: While the strap is set, a 1 on `lo_cmd_i[i]` forces `hi_gate_o[i]` off, whatever `hi_cmd_n_i[i]` is. The forced turn-off appears on the third rising edge.
- R3: With all high-side commands held at 0 and the strap set, each phase runs complementary from `lo_cmd_i` alone. A 1 selects the low gate and a 0 selects the high gate, with the dead time before each turn-on.
- R4: While the strap is set, a turn-on appears on rising edge DT_CYC+2 after the request starts (DT_CYC defaults to 6), and never earlier. A turn-off appears on the third edge.
- R5: A request that stays high for fewer than DT_CYC synchronized cycles produces no turn-on. A request that drops for one cycle restarts the full dead-time count.
- R6: While the strap is clear, both gates follow their commands on the third rising edge, with no dead time and no interlock. Both gates of one phase may be on together.
- R7: While `dis_i` is 1, all six outputs are off, including during the start-up charge interval. After `dis_i` returns to 0, turn-on again waits for the dead time.
- R8: While `uv_i` is 1, all six outputs are off. After `uv_i` returns to 0, turn-on again waits for the dead time.
- R9: After reset is released, the block runs a charge interval of REFRESH_CYC+REFRESH_EXT cycles (24 by default). During it, all low gates are requested on, and they still wait for the dead time: with the strap set they first turn on at edge DT_CYC. All high gates stay off. Normal control applies from the edge after the interval ends.
- R10: While reset is asserted, all six outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_cmd_n_i | input | NUM_PH | High-side commands, active low, one bit per phase |
| lo_cmd_i | input | NUM_PH | Low-side commands, active high, one bit per phase |
| dis_i | input | 1 | Global disable; 1 forces every output off |
| uv_i | input | 1 | Undervoltage flag; 1 forces every output off |
| guard_en_i | input | 1 | Strap: 1 enables dead time and interlock, 0 bypasses both |
| hi_gate_o | output | NUM_PH | High-side gate enables |
| lo_gate_o | output | NUM_PH | Low-side gate enables |

## Verification
The bench targets the edges where the dead time ends. It checks that a turn-on is still absent one cycle before it is due, so a design with a short or missing count shows a gate that closes early. It also drives a request one cycle shorter than the dead time, and a request that drops for a single cycle; a counter that does not restart on a drop would let the glitch reach the gate. Low-side priority is tested with the high-side command still asserted, where a missing interlock leaves both gates on. Disable is also held through the start-up charge interval, where a design that lets the charge interval win over disable would turn the low gates on.

// File: rtl/bgi_pkg.sv
package bgi_pkg;

    // How a phase slice interprets its commands in the current cycle.
    typedef enum logic [1:0] {
        DRV_OFF    = 2'd0,   // forced off by disable or undervoltage
        DRV_CHARGE = 2'd1,   // start-up charge interval: lows on, highs off
        DRV_FOLLOW = 2'd2    // normal command control
    } drive_mode_e;

    // Bits needed for a counter that must hold the value n.
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/bgi_sync.sv
module bgi_sync #(
    parameter int unsigned    W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s2;
        logic [W-1:0] s1;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s2: RST_VAL, s1: RST_VAL};
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/bgi_refresh.sv
module bgi_refresh #(
    parameter int unsigned LEN = 24
) (
    input  logic clk,
    input  logic rst_n,
    output logic active_o
);
    localparam int unsigned RW = bgi_pkg::cnt_bits(LEN);
    localparam logic [RW-1:0] DONE = RW'(LEN);

    typedef struct packed {
        logic [RW-1:0] cnt;
    } rfr_t;

    rfr_t st_d, st_q;
    logic running;

    assign running = (st_q.cnt != DONE);

    always_comb begin
        st_d = st_q;
        if (running) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = running;
endmodule

// File: rtl/bgi_deadtime.sv
// One gate output: delays turn-on by DT_CYC cycles of continuous request,
// drops at once when the request goes away. DT_CYC must be at least 1.
module bgi_deadtime #(
    parameter int unsigned DT_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    input  logic guard_en_i,
    output logic gate_o
);
    localparam int unsigned CW = bgi_pkg::cnt_bits(DT_CYC);
    localparam logic [CW-1:0] LAST = CW'(DT_CYC - 1);

    typedef struct packed {
        logic          gate;
        logic [CW-1:0] cnt;
    } dt_t;

    dt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!want_i) begin
            st_d = '0;                      // off at once, count restarts
        end else if (!guard_en_i) begin
            st_d.gate = 1'b1;               // bypass: follow directly
            st_d.cnt  = '0;
        end else if (st_q.gate) begin
            st_d.cnt  = '0;                 // already on, hold
        end else if (st_q.cnt == LAST) begin
            st_d.gate = 1'b1;               // dead time elapsed
            st_d.cnt  = '0;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_o = st_q.gate;
endmodule

// File: rtl/bgi_phase.sv
module bgi_phase
    import bgi_pkg::*;
#(
    parameter int unsigned DT_CYC = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  drive_mode_e mode_i,
    input  logic        guard_en_i,
    input  logic        hi_cmd_n_i,
    input  logic        lo_cmd_i,
    output logic        hi_gate_o,
    output logic        lo_gate_o
);
    typedef struct packed {
        logic hi;
        logic lo;
    } want_t;

    want_t want;

    always_comb begin
        want = '0;
        unique case (mode_i)
            DRV_CHARGE: begin
                want.hi = 1'b0;
                want.lo = 1'b1;
            end
            DRV_FOLLOW: begin
                want.lo = lo_cmd_i;
                // low side wins over high side while guarding is on
                want.hi = !hi_cmd_n_i && !(guard_en_i && lo_cmd_i);
            end
            default: want = '0;
        endcase
    end

    bgi_deadtime #(.DT_CYC(DT_CYC)) u_hi (
        .clk        (clk),
        .rst_n      (rst_n),
        .want_i     (want.hi),
        .guard_en_i (guard_en_i),
        .gate_o     (hi_gate_o)
    );

    bgi_deadtime #(.DT_CYC(DT_CYC)) u_lo (
        .clk        (clk),
        .rst_n      (rst_n),
        .want_i     (want.lo),
        .guard_en_i (guard_en_i),
        .gate_o     (lo_gate_o)
    );
endmodule

// File: rtl/bridge_gate_interlock.sv
module bridge_gate_interlock
    import bgi_pkg::*;
#(
    parameter int unsigned NUM_PH      = 3,
    parameter int unsigned DT_CYC      = 6,
    parameter int unsigned REFRESH_CYC = 20,
    parameter int unsigned REFRESH_EXT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PH-1:0] hi_cmd_n_i,
    input  logic [NUM_PH-1:0] lo_cmd_i,
    input  logic              dis_i,
    input  logic              uv_i,
    input  logic              guard_en_i,
    output logic [NUM_PH-1:0] hi_gate_o,
    output logic [NUM_PH-1:0] lo_gate_o
);
    localparam int unsigned CHARGE_LEN = REFRESH_CYC + REFRESH_EXT;

    logic [NUM_PH-1:0] hi_n_s;
    logic [NUM_PH-1:0] lo_s;
    logic [2:0]        ctl_s;
    logic              dis_s, uv_s, dten_s;
    logic              refr;
    drive_mode_e       mode;

    // High commands reset to "off" (1); strap resets to guarded.
    bgi_sync #(.W(NUM_PH), .RST_VAL({NUM_PH{1'b1}})) u_sync_hi (
        .clk (clk), .rst_n (rst_n), .d_i (hi_cmd_n_i), .q_o (hi_n_s)
    );

    bgi_sync #(.W(NUM_PH), .RST_VAL({NUM_PH{1'b0}})) u_sync_lo (
        .clk (clk), .rst_n (rst_n), .d_i (lo_cmd_i), .q_o (lo_s)
    );

    bgi_sync #(.W(3), .RST_VAL(3'b001)) u_sync_ctl (
        .clk (clk), .rst_n (rst_n), .d_i ({dis_i, uv_i, guard_en_i}), .q_o (ctl_s)
    );

    assign dis_s  = ctl_s[2];
    assign uv_s   = ctl_s[1];
    assign dten_s = ctl_s[0];

    bgi_refresh #(.LEN(CHARGE_LEN)) u_refresh (
        .clk (clk), .rst_n (rst_n), .active_o (refr)
    );

    always_comb begin
        if (dis_s || uv_s) mode = DRV_OFF;
        else if (refr)     mode = DRV_CHARGE;
        else               mode = DRV_FOLLOW;
    end

    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        bgi_phase #(.DT_CYC(DT_CYC)) u_phase (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode_i     (mode),
            .guard_en_i (dten_s),
            .hi_cmd_n_i (hi_n_s[p]),
            .lo_cmd_i   (lo_s[p]),
            .hi_gate_o  (hi_gate_o[p]),
            .lo_gate_o  (lo_gate_o[p])
        );
    end
endmodule

// File: rtl/bgi_chk.sv
module bgi_chk #(
    parameter int unsigned NUM_PH = 3,
    parameter int unsigned DT_CYC = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_PH-1:0] hi_gate,
    input logic [NUM_PH-1:0] lo_gate,
    input logic [NUM_PH-1:0] hi_n_s,
    input logic [NUM_PH-1:0] lo_s,
    input logic              dis_s,
    input logic              uv_s,
    input logic              dten_s,
    input logic              refr
);
    localparam int unsigned CW = bgi_pkg::cnt_bits(DT_CYC);
    localparam logic [CW-1:0] CAP = CW'(DT_CYC);
    localparam logic [CW-1:0] MIN_GAP = CW'(DT_CYC - 1);

    // R7 R8
    // force_off_chk
    force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_s || uv_s) |=> (hi_gate == '0 && lo_gate == '0));

    // R9
    // refresh_hi_chk
    refresh_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refr |-> (hi_gate == '0));

    for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
        logic [CW-1:0] off_q;

        // cycles both gates of this phase have been off, saturating
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      off_q <= '0;
            else if (hi_gate[p] || lo_gate[p]) off_q <= '0;
            else if (off_q != CAP)           off_q <= off_q + 1'b1;
        end

        // R1
        // hi_off_chk
        hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hi_n_s[p] |=> !hi_gate[p]);

        // R4
        // lo_off_chk
        lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!lo_s[p] && !refr) |=> !lo_gate[p]);

        // R2
        // shoot_thru_chk
        shoot_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dten_s && $past(dten_s)) |-> !(hi_gate[p] && lo_gate[p]));

        // R4
        // guard_gap_chk
        guard_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (($rose(lo_gate[p]) || $rose(hi_gate[p])) && $past(dten_s))
                |-> (off_q >= MIN_GAP));
    end
endmodule

bind bridge_gate_interlock bgi_chk #(.NUM_PH(NUM_PH), .DT_CYC(DT_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hi_gate (hi_gate_o),
    .lo_gate (lo_gate_o),
    .hi_n_s  (hi_n_s),
    .lo_s    (lo_s),
    .dis_s   (dis_s),
    .uv_s    (uv_s),
    .dten_s  (dten_s),
    .refr    (refr)
);

// File: tb/sim_bridge_gate_interlock.sv
`timescale 1ns/1ps
module sim_bridge_gate_interlock;
    localparam int NP = 3;
    localparam int DT = 6;
    localparam int RC = 20;
    localparam int RE = 4;
    localparam int RL = RC + RE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] hi_n = '1;
    logic [NP-1:0] lo = '0;
    logic          dis = 1'b0;
    logic          uv = 1'b0;
    logic          gen = 1'b1;
    logic [NP-1:0] hi_g, lo_g;

    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;   // 125 MHz

    bridge_gate_interlock #(
        .NUM_PH(NP), .DT_CYC(DT), .REFRESH_CYC(RC), .REFRESH_EXT(RE)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .hi_cmd_n_i(hi_n), .lo_cmd_i(lo),
        .dis_i(dis), .uv_i(uv), .guard_en_i(gen),
        .hi_gate_o(hi_g), .lo_gate_o(lo_g)
    );

    task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive all inputs at a falling edge; the next rising edge is edge 0.
    task automatic drv(input logic [NP-1:0] h, input logic [NP-1:0] l,
                       input logic d, input logic u, input logic g);
        @(negedge clk);
        hi_n = h; lo = l; dis = d; uv = u; gen = g;
    endtask

    // Pass k rising edges, then sample 2 ns later.
    task automatic edges(input int k);
        repeat (k) @(posedge clk);
        #2;
    endtask

    task automatic idle();
        drv('1, '0, 1'b0, 1'b0, 1'b1);
        edges(12);
    endtask

    task automatic do_reset(input logic d);
        @(negedge clk);
        rst_n = 1'b0; hi_n = '1; lo = '0; dis = d; uv = 1'b0; gen = 1'b1;
        edges(3);
        chk("R10 reset hi", hi_g, '0);
        chk("R10 reset lo", lo_g, '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_dis_charge();
        do_reset(1'b1);
        edges(DT + 2);
        chk("R7 disable over charge lo", lo_g, '0);
        chk("R7 disable over charge hi", hi_g, '0);
    endtask

    task automatic t_charge();
        do_reset(1'b0);
        edges(DT - 1);
        chk("R9 charge lo before dead time", lo_g, '0);
        edges(1);
        chk("R9 charge lo on", lo_g, '1);
        chk("R9 charge hi off", hi_g, '0);
        edges(RL - DT);
        chk("R9 charge lo still on at end", lo_g, '1);
        edges(1);
        chk("R9 normal control after charge", lo_g, '0);
    endtask

    task automatic t_priority();
        idle();
        drv(3'b110, 3'b000, 1'b0, 1'b0, 1'b1);
        edges(DT + 1);
        chk("R4 hi turn-on not early", hi_g, 3'b000);
        edges(1);
        chk("R1 hi on from low command", hi_g, 3'b001);
        drv(3'b110, 3'b001, 1'b0, 1'b0, 1'b1);
        edges(2);
        chk("R2 hi still on before sync", hi_g, 3'b001);
        edges(1);
        chk("R2 low overrides high", hi_g, 3'b000);
        edges(DT - 2);
        chk("R4 lo turn-on not early", lo_g, 3'b000);
        edges(1);
        chk("R4 lo on after dead time", lo_g, 3'b001);
        drv(3'b110, 3'b000, 1'b0, 1'b0, 1'b1);
        edges(3);
        chk("R4 lo off on third edge", lo_g, 3'b000);
        edges(DT - 1);
        chk("R3 hi returns after dead time", hi_g, 3'b001);
        drv(3'b111, 3'b000, 1'b0, 1'b0, 1'b1);
        edges(3);
        chk("R1 high command 1 turns gate off", hi_g, 3'b000);
    endtask

    task automatic t_complement();
        idle();
        drv(3'b000, 3'b000, 1'b0, 1'b0, 1'b1);
        edges(DT + 2);
        chk("R3 all highs on", hi_g, 3'b111);
        drv(3'b000, 3'b101, 1'b0, 1'b0, 1'b1);
        edges(DT + 2);
        chk("R3 complementary hi", hi_g, 3'b010);
        chk("R3 complementary lo", lo_g, 3'b101);
    endtask

    task automatic t_force(input bit use_uv, input string tag);
        // starts from the complementary state
        drv(3'b000, 3'b101, !use_uv, use_uv, 1'b1);
        edges(3);
        chk({tag, " forced off hi"}, hi_g, 3'b000);
        chk({tag, " forced off lo"}, lo_g, 3'b000);
        edges(10);
        chk({tag, " held off"}, hi_g | lo_g, 3'b000);
        drv(3'b000, 3'b101, 1'b0, 1'b0, 1'b1);
        edges(DT + 1);
        chk({tag, " release waits dead time"}, hi_g | lo_g, 3'b000);
        edges(1);
        chk({tag, " release hi"}, hi_g, 3'b010);
        chk({tag, " release lo"}, lo_g, 3'b101);
    endtask

    task automatic t_glitch();
        logic [NP-1:0] acc;
        idle();
        acc = '0;
        drv(3'b111, 3'b010, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < DT - 1; i++) begin edges(1); acc |= lo_g; end
        drv(3'b111, 3'b000, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 12; i++) begin edges(1); acc |= lo_g; end
        chk("R5 short request gives no pulse", acc, 3'b000);
        acc = '0;
        drv(3'b111, 3'b010, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < DT - 1; i++) begin edges(1); acc |= lo_g; end
        drv(3'b111, 3'b000, 1'b0, 1'b0, 1'b1);
        edges(1); acc |= lo_g;
        drv(3'b111, 3'b010, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < DT + 1; i++) begin edges(1); acc |= lo_g; end
        chk("R5 one-cycle drop restarts count", acc, 3'b000);
        edges(1);
        chk("R5 on after full restarted count", lo_g, 3'b010);
    endtask

    task automatic t_bypass();
        idle();
        drv(3'b111, 3'b000, 1'b0, 1'b0, 1'b0);
        edges(6);
        drv(3'b011, 3'b100, 1'b0, 1'b0, 1'b0);
        edges(2);
        chk("R6 bypass not before third edge", hi_g | lo_g, 3'b000);
        edges(1);
        chk("R6 bypass hi follows", hi_g, 3'b100);
        chk("R6 bypass lo follows with hi", lo_g, 3'b100);
        drv(3'b111, 3'b000, 1'b0, 1'b0, 1'b0);
        edges(3);
        chk("R6 bypass turn-off", hi_g | lo_g, 3'b000);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : main
        t_dis_charge();
        t_charge();
        t_priority();
        t_complement();
        t_force(1'b0, "R7 disable");
        idle();
        t_complement();
        t_force(1'b1, "R8 undervoltage");
        t_glitch();
        t_bypass();
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule